// File: doc/BRIEF.md
# Paged NIC Host Register File

This block is the byte-wide host register interface of a legacy Ethernet controller core. A host reaches it through a small address window of sixteen offsets. A command byte at offset 0 is visible in every page. Two page-select bits in that byte choose which register bank answers at offsets 1 to 15. In the live page (page 0), some offsets reach a status value on a read and a configuration register on a write. The shadow page (page 2) lets software read back those write-only values. The station page (page 1) holds the station address, the current-page pointer and the multicast filter.

The block holds the interrupt status and mask registers and drives a level interrupt. It exports control fields to the transmit, receive and remote-DMA engines:
- run state
- transmit request
- remote-DMA command
- loopback mode
- receive configuration
- ring pointers
- transmit page and byte count

Those engines return one-cycle event pulses. A pulse sets a status bit, and some pulses also retire a command field.

A run-state machine governs start and stop. It has three states:
- **ACTIVE**: the core is running.
- **DRAIN**: a stop has been requested and the core is winding down.
- **HALTED**: the core is stopped.

It has four transitions:
- **stop-request** (ACTIVE to DRAIN) is taken when the stop bit is written.
- **drain-done** (DRAIN to HALTED) is taken after `DRAIN_CYCLES` clock cycles and sets the reset-status bit.
- **restart** (DRAIN or HALTED to ACTIVE) is taken when the start bit is written without the stop bit.
- **hold** is taken in every other case, and the state does not change.

Top module: `nic_regfile`

## Requirements
- R1: After reset the command byte reads 0x21 (stopped, remote-DMA code 4, page 0), interrupt status reads 0x80, the mask is 0 and `irq` is low.
- R2: Offset 0 is the command byte in every page. Its bit 0 reads 1 when the core is not ACTIVE, bit 1 reads 1 when it is ACTIVE, bit 2 is the transmit request, bits 5:3 are the remote-DMA code and bits 7:6 are the page select that decodes offsets 1 to 15.
- R3: Page 0 is direction-split.
  - Offsets 1 and 2 read the low and high bytes of `ldma_addr`, but writes to them set the ring start and ring stop pages.
  - Offset 3 is the ring boundary and can be read and written.
  - Offset 4 writes the transmit page, and offsets 5 and 6 write the low and high bytes of the transmit count.
  - Offset 12 writes the receive configuration, offset 13 writes the transmit configuration and offset 15 writes the mask.
  - `ctl_loopback` is bits 2:1 of the transmit configuration.
- R4: In page 1, offsets 1 to 6 are station-address bytes 0 to 5 (byte n at `station_addr[8n+7:8n]`), offset 7 is the current page and offsets 8 to 15 are multicast bytes. All of them can be read and written.
- R5: Page 2 reads back the ring start, ring stop, transmit page, receive configuration, transmit configuration and mask at the page-0 offsets those registers are written at. Writes at offsets 1 to 15 in pages 2 and 3 are ignored, and page-3 reads at offsets 1 to 15 return 0.
- R6: Page 0 offset 7 is the interrupt status, with these bits:
  - bit 0: receive done
  - bit 1: transmit done
  - bit 2: receive error
  - bit 3: transmit error
  - bit 4: ring overwrite
  - bit 5: counter overflow
  - bit 6: remote-DMA done
  - bit 7: reset status

  Writing a 1 to a bit clears it, and writing 0 leaves it unchanged.
- R7: An event pulse `ev_set[n]` sets status bit n at the next edge, even if a host write clears that bit in the same cycle.
- R8: `irq` is high exactly when some status bit and its mask bit are both 1.
- R9: Writing the command byte with bit 2 set raises the transmit request. Writing it with bit 2 clear leaves the request unchanged. A transmit-done or transmit-error pulse (`ev_set[1]` or `ev_set[3]`) clears the request.
- R10: The remote-DMA code is written from command bits 5:3 (1 read, 2 write, 3 send, 4 abort/complete). A remote-DMA-done pulse (`ev_set[6]`) returns the code to 4 unless the command byte is being written in that cycle.
- R11: Writing command bit 0 moves the core from ACTIVE to DRAIN, and stop wins over a start bit written at the same time. Exactly `DRAIN_CYCLES` edges after entering DRAIN, the state becomes HALTED and status bit 7 sets.
- R12: Writing command bit 1 without bit 0 moves the core from DRAIN or HALTED to ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the current offset and page |
| ldma_addr | input | 16 | Current local-DMA address from the DMA engine |
| ev_set | input | 8 | Event pulses, one per status bit |
| irq | output | 1 | Interrupt request |
| ctl_start | output | 1 | Core is ACTIVE |
| ctl_stop | output | 1 | Core is draining or halted |
| ctl_tx_req | output | 1 | Transmit request |
| ctl_rdma_cmd | output | 3 | Remote-DMA code |
| ctl_loopback | output | 2 | Loopback mode |
| ctl_rx_cfg | output | 6 | Receive configuration |
| ring_start | output | 8 | Receive ring first page |
| ring_stop | output | 8 | Receive ring end page |
| ring_boundary | output | 8 | Receive ring boundary page |
| tx_page | output | 8 | Transmit buffer start page |
| tx_count | output | 16 | Transmit byte count |
| station_addr | output | 8*STN_BYTES | Station address bytes |
| mcast_filter | output | 8*MC_BYTES | Multicast filter bytes |
| cur_page | output | 8 | Current receive page |

## Verification
Most internal state errors appear on `host_rdata` in the same cycle as a read. A wrong page or direction decode shows as a value from the wrong bank. A lost event shows as a status bit that reads 0 one edge after its pulse, and `irq` follows the status register at that same edge. The drain counter is checked cycle by cycle: status bit 7 must read 0 at every read before the fourth edge after the stop write, and 1 at the read immediately after it, so an off-by-one counter appears within a single cycle.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [2:0] RDMA_READ  = 3'd1;
    localparam logic [2:0] RDMA_WRITE = 3'd2;
    localparam logic [2:0] RDMA_SEND  = 3'd3;
    localparam logic [2:0] RDMA_IDLE  = 3'd4;

    localparam int unsigned EV_TX_DONE  = 1;
    localparam int unsigned EV_TX_ERR   = 3;
    localparam int unsigned EV_RDMA_END = 6;
    localparam int unsigned EV_HALTED   = 7;

    typedef enum logic [1:0] {
        RUN_ACTIVE = 2'd0,
        RUN_DRAIN  = 2'd1,
        RUN_HALTED = 2'd2
    } run_state_e;

    typedef enum logic [4:0] {
        RID_NONE, RID_CMD, RID_RSTART, RID_RSTOP, RID_BOUND,
        RID_TXPG, RID_TXCLO, RID_TXCHI, RID_STAT, RID_RXCFG,
        RID_TXCFG, RID_MASK, RID_LDMA_LO, RID_LDMA_HI,
        RID_STN, RID_CURR, RID_MCAST
    } reg_id_e;

endpackage

// File: rtl/nic_page_decode.sv
module nic_page_decode
    import nic_regs_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned STN_BYTES = 6,
    parameter int unsigned MC_BYTES  = 8
) (
    input  logic              en,
    input  logic              is_write,
    input  logic [1:0]        page,
    input  logic [ADDR_W-1:0] addr,
    output reg_id_e           id
);
    localparam int CURR_OFS = STN_BYTES + 1;
    localparam int MC_BASE  = STN_BYTES + 2;

    always_comb begin
        id = RID_NONE;
        if (en) begin
            if (int'(addr) == 0) begin
                id = RID_CMD;
            end else begin
                unique case (page)
                    2'd0: begin
                        case (int'(addr))
                            1:  id = is_write ? RID_RSTART : RID_LDMA_LO;
                            2:  id = is_write ? RID_RSTOP  : RID_LDMA_HI;
                            3:  id = RID_BOUND;
                            4:  id = is_write ? RID_TXPG  : RID_NONE;
                            5:  id = is_write ? RID_TXCLO : RID_NONE;
                            6:  id = is_write ? RID_TXCHI : RID_NONE;
                            7:  id = RID_STAT;
                            12: id = is_write ? RID_RXCFG : RID_NONE;
                            13: id = is_write ? RID_TXCFG : RID_NONE;
                            15: id = is_write ? RID_MASK  : RID_NONE;
                            default: id = RID_NONE;
                        endcase
                    end
                    2'd1: begin
                        if (int'(addr) <= STN_BYTES)
                            id = RID_STN;
                        else if (int'(addr) == CURR_OFS)
                            id = RID_CURR;
                        else if (int'(addr) >= MC_BASE && int'(addr) < MC_BASE + MC_BYTES)
                            id = RID_MCAST;
                    end
                    2'd2: begin
                        if (!is_write) begin
                            case (int'(addr))
                                1:  id = RID_RSTART;
                                2:  id = RID_RSTOP;
                                4:  id = RID_TXPG;
                                12: id = RID_RXCFG;
                                13: id = RID_TXCFG;
                                15: id = RID_MASK;
                                default: id = RID_NONE;
                            endcase
                        end
                    end
                    2'd3: id = RID_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
    import nic_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_we,
    input  logic              mask_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] ev_set,
    input  logic              halt_evt,
    output logic [BYTE_W-1:0] status_q,
    output logic [BYTE_W-1:0] mask_q,
    output logic              irq
);
    logic [BYTE_W-1:0] clr_bits;
    logic [BYTE_W-1:0] set_bits;
    logic [BYTE_W-1:0] status_d;

    always_comb begin
        clr_bits = clr_we ? wdata : '0;
        set_bits = ev_set;
        set_bits[EV_HALTED] = ev_set[EV_HALTED] | halt_evt;
        status_d = (status_q & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= BYTE_W'(1) << EV_HALTED;
            mask_q   <= '0;
        end else begin
            status_q <= status_d;
            if (mask_we)
                mask_q <= wdata;
        end
    end

    assign irq = |(status_q & mask_q);
endmodule

// File: rtl/nic_run_fsm.sv
module nic_run_fsm
    import nic_regs_pkg::*;
#(
    parameter int unsigned DRAIN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_wr,
    input  logic start_wr,
    output logic running,
    output logic halted,
    output logic halt_evt
);
    localparam int unsigned CNT_W = $clog2(DRAIN_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DRAIN_CYCLES - 1);

    run_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              go;

    assign go = start_wr && !stop_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RUN_HALTED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_ACTIVE: if (stop_wr) state_d = RUN_DRAIN;
            RUN_DRAIN: begin
                if (go)                    state_d = RUN_ACTIVE;
                else if (cnt_q == CNT_LAST) state_d = RUN_HALTED;
            end
            RUN_HALTED: if (go) state_d = RUN_ACTIVE;
            default: state_d = RUN_HALTED;
        endcase
        cnt_d = (state_q == RUN_DRAIN && state_d == RUN_DRAIN) ? cnt_q + 1'b1 : '0;
    end

    always_comb begin
        running  = (state_q == RUN_ACTIVE);
        halted   = (state_q == RUN_HALTED);
        halt_evt = (state_q == RUN_DRAIN) && (state_d == RUN_HALTED);
    end
endmodule

// File: rtl/nic_regfile.sv
module nic_regfile
    import nic_regs_pkg::*;
#(
    parameter int unsigned ADDR_W       = 4,
    parameter int unsigned STN_BYTES    = 6,
    parameter int unsigned MC_BYTES     = 8,
    parameter int unsigned DRAIN_CYCLES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_sel,
    input  logic                      host_wr,
    input  logic [ADDR_W-1:0]         host_addr,
    input  logic [7:0]                host_wdata,
    output logic [7:0]                host_rdata,
    input  logic [15:0]               ldma_addr,
    input  logic [7:0]                ev_set,
    output logic                      irq,
    output logic                      ctl_start,
    output logic                      ctl_stop,
    output logic                      ctl_tx_req,
    output logic [2:0]                ctl_rdma_cmd,
    output logic [1:0]                ctl_loopback,
    output logic [5:0]                ctl_rx_cfg,
    output logic [7:0]                ring_start,
    output logic [7:0]                ring_stop,
    output logic [7:0]                ring_boundary,
    output logic [7:0]                tx_page,
    output logic [15:0]               tx_count,
    output logic [8*STN_BYTES-1:0]    station_addr,
    output logic [8*MC_BYTES-1:0]     mcast_filter,
    output logic [7:0]                cur_page
);
    localparam int MC_BASE = STN_BYTES + 2;

    reg_id_e           wr_id, rd_id;
    logic [1:0]        page_q;
    logic [2:0]        rdma_q;
    logic              tx_req_q;
    logic [7:0]        rstart_q, rstop_q, bound_q, txpg_q, rxcfg_q, txcfg_q, curr_q;
    logic [15:0]       txcnt_q;
    logic [7:0]        stn_q [STN_BYTES];
    logic [7:0]        mc_q  [MC_BYTES];
    logic [7:0]        status_q, mask_q;
    logic              cmd_we, running, fsm_halted, halt_evt;
    logic              tx_done, rdma_done;

    nic_page_decode #(.ADDR_W(ADDR_W), .STN_BYTES(STN_BYTES), .MC_BYTES(MC_BYTES)) u_wdec (
        .en(host_sel && host_wr), .is_write(1'b1), .page(page_q), .addr(host_addr), .id(wr_id)
    );
    nic_page_decode #(.ADDR_W(ADDR_W), .STN_BYTES(STN_BYTES), .MC_BYTES(MC_BYTES)) u_rdec (
        .en(1'b1), .is_write(1'b0), .page(page_q), .addr(host_addr), .id(rd_id)
    );

    assign cmd_we    = (wr_id == RID_CMD);
    assign tx_done   = ev_set[EV_TX_DONE] | ev_set[EV_TX_ERR];
    assign rdma_done = ev_set[EV_RDMA_END];

    nic_run_fsm #(.DRAIN_CYCLES(DRAIN_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .stop_wr(cmd_we && host_wdata[0]),
        .start_wr(cmd_we && host_wdata[1]),
        .running(running), .halted(fsm_halted), .halt_evt(halt_evt)
    );

    nic_irq_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .clr_we(wr_id == RID_STAT), .mask_we(wr_id == RID_MASK),
        .wdata(host_wdata), .ev_set(ev_set), .halt_evt(halt_evt),
        .status_q(status_q), .mask_q(mask_q), .irq(irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q   <= '0;
            rdma_q   <= RDMA_IDLE;
            tx_req_q <= 1'b0;
            rstart_q <= '0;
            rstop_q  <= '0;
            bound_q  <= '0;
            txpg_q   <= '0;
            txcnt_q  <= '0;
            rxcfg_q  <= '0;
            txcfg_q  <= '0;
            curr_q   <= '0;
            for (int i = 0; i < STN_BYTES; i++) stn_q[i] <= '0;
            for (int i = 0; i < MC_BYTES; i++)  mc_q[i]  <= '0;
        end else begin
            if (cmd_we) begin
                page_q <= host_wdata[7:6];
                rdma_q <= host_wdata[5:3];
            end else if (rdma_done) begin
                rdma_q <= RDMA_IDLE;
            end
            if (cmd_we && host_wdata[2])
                tx_req_q <= 1'b1;
            else if (tx_done)
                tx_req_q <= 1'b0;
            if (wr_id == RID_RSTART) rstart_q <= host_wdata;
            if (wr_id == RID_RSTOP)  rstop_q  <= host_wdata;
            if (wr_id == RID_BOUND)  bound_q  <= host_wdata;
            if (wr_id == RID_TXPG)   txpg_q   <= host_wdata;
            if (wr_id == RID_TXCLO)  txcnt_q[7:0]  <= host_wdata;
            if (wr_id == RID_TXCHI)  txcnt_q[15:8] <= host_wdata;
            if (wr_id == RID_RXCFG)  rxcfg_q  <= host_wdata;
            if (wr_id == RID_TXCFG)  txcfg_q  <= host_wdata;
            if (wr_id == RID_CURR)   curr_q   <= host_wdata;
            for (int i = 0; i < STN_BYTES; i++)
                if (wr_id == RID_STN && int'(host_addr) == i + 1) stn_q[i] <= host_wdata;
            for (int i = 0; i < MC_BYTES; i++)
                if (wr_id == RID_MCAST && int'(host_addr) == i + MC_BASE) mc_q[i] <= host_wdata;
        end
    end

    always_comb begin
        host_rdata = '0;
        case (rd_id)
            RID_CMD:     host_rdata = {page_q, rdma_q, tx_req_q, running, !running};
            RID_LDMA_LO: host_rdata = ldma_addr[7:0];
            RID_LDMA_HI: host_rdata = ldma_addr[15:8];
            RID_RSTART:  host_rdata = rstart_q;
            RID_RSTOP:   host_rdata = rstop_q;
            RID_BOUND:   host_rdata = bound_q;
            RID_TXPG:    host_rdata = txpg_q;
            RID_STAT:    host_rdata = status_q;
            RID_RXCFG:   host_rdata = rxcfg_q;
            RID_TXCFG:   host_rdata = txcfg_q;
            RID_MASK:    host_rdata = mask_q;
            RID_CURR:    host_rdata = curr_q;
            RID_STN:
                for (int i = 0; i < STN_BYTES; i++)
                    if (int'(host_addr) == i + 1) host_rdata = stn_q[i];
            RID_MCAST:
                for (int i = 0; i < MC_BYTES; i++)
                    if (int'(host_addr) == i + MC_BASE) host_rdata = mc_q[i];
            default:     host_rdata = '0;
        endcase
    end

    generate
        for (genvar g = 0; g < STN_BYTES; g++) begin : g_stn
            assign station_addr[8*g +: 8] = stn_q[g];
        end
        for (genvar g = 0; g < MC_BYTES; g++) begin : g_mc
            assign mcast_filter[8*g +: 8] = mc_q[g];
        end
    endgenerate

    assign ctl_start     = running;
    assign ctl_stop      = !running;
    assign ctl_tx_req    = tx_req_q;
    assign ctl_rdma_cmd  = rdma_q;
    assign ctl_loopback  = txcfg_q[2:1];
    assign ctl_rx_cfg    = rxcfg_q[5:0];
    assign ring_start    = rstart_q;
    assign ring_stop     = rstop_q;
    assign ring_boundary = bound_q;
    assign tx_page       = txpg_q;
    assign tx_count      = txcnt_q;
    assign cur_page      = curr_q;
endmodule

// File: rtl/nic_regfile_chk.sv
module nic_regfile_chk #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_sel,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [7:0]        host_wdata,
    input logic [7:0]        ev_set,
    input logic              irq,
    input logic              ctl_start,
    input logic              ctl_tx_req,
    input logic [2:0]        ctl_rdma_cmd,
    input logic [7:0]        status_q,
    input logic [7:0]        mask_q,
    input logic              fsm_halted
);
    logic cmd_wr;
    assign cmd_wr = host_sel && host_wr && (host_addr == '0);

    AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_set != 8'h00) |=> ((status_q & $past(ev_set)) == $past(ev_set))); // R7

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 8'h00) |-> !irq); // R8

    AST_TX_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_set[1] || ev_set[3]) && !(cmd_wr && ((host_wdata & 8'h04) != 8'h00))) |=> !ctl_tx_req); // R9

    AST_RDMA_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_set[6] && !cmd_wr) |=> (ctl_rdma_cmd == 3'd4)); // R10

    AST_STOP_LEAVES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && ((host_wdata & 8'h01) != 8'h00)) |=> !ctl_start); // R11

    AST_HALT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsm_halted) |-> status_q[7]); // R11
endmodule

bind nic_regfile nic_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_nic_regfile.sv
`timescale 1ns/1ps
module test_nic_regfile;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_sel, host_wr;
    logic [3:0]  host_addr;
    logic [7:0]  host_wdata, host_rdata, ev_set;
    logic [15:0] ldma_addr;
    logic        irq, ctl_start, ctl_stop, ctl_tx_req;
    logic [2:0]  ctl_rdma_cmd;
    logic [1:0]  ctl_loopback;
    logic [5:0]  ctl_rx_cfg;
    logic [7:0]  ring_start, ring_stop, ring_boundary, tx_page, cur_page;
    logic [15:0] tx_count;
    logic [47:0] station_addr;
    logic [63:0] mcast_filter;

    typedef struct { int kind; logic [7:0] exp; string tag; } item_t;
    item_t sb_q[$];
    logic  probe = 1'b0;
    int    n_vec = 0, n_bad = 0;
    bit    done = 0;

    always #10 clk = ~clk;

    nic_regfile i_nic_regfile (.*);

    // monitor: compares away from the rising edge
    always begin
        @(negedge clk);
        #5;
        if (probe && sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0: act = host_rdata;
                1: act = {7'd0, irq};
                2: act = station_addr[15:8];
                3: act = {6'd0, ctl_loopback};
                default: act = {7'd0, ctl_tx_req};
            endcase
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got 0x%02h expected 0x%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 0; host_wr = 0;
    endtask

    task automatic wr_ev(input logic [3:0] a, input logic [7:0] d, input logic [7:0] e);
        ev_set = e;
        wr(a, d);
        ev_set = 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.kind = 0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        host_sel = 1; host_wr = 0; host_addr = a; probe = 1;
        @(negedge clk);
        host_sel = 0; probe = 0;
    endtask

    task automatic chk(input int k, input logic [7:0] e, input string tag);
        item_t it;
        it.kind = k; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        probe = 1;
        @(negedge clk);
        probe = 0;
    endtask

    task automatic pulse(input logic [7:0] e);
        ev_set = e;
        @(negedge clk);
        ev_set = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; host_sel = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
        ev_set = 0; ldma_addr = 16'hBEEF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        rd(0, 8'h21, "R1 cmd");
        rd(7, 8'h80, "R1 status");
        chk(1, 8'h00, "R1 irq");
        wr(7, 8'hFF);
        rd(7, 8'h00, "R6 w1c all");
        wr(0, 8'h22);
        rd(0, 8'h22, "R12 start");

        wr(1, 8'h46); wr(2, 8'h80); wr(3, 8'h7F);
        rd(1, 8'hEF, "R3 ldma lo");
        rd(2, 8'hBE, "R3 ldma hi");
        rd(3, 8'h7F, "R3 boundary");
        wr(12, 8'h04); wr(13, 8'h04);
        chk(3, 8'h02, "R3 loopback");

        wr(0, 8'hA2);
        rd(0, 8'hA2, "R2 cmd page2");
        rd(1, 8'h46, "R5 ring start");
        rd(2, 8'h80, "R5 ring stop");
        rd(12, 8'h04, "R5 rx cfg");
        wr(1, 8'h11);
        rd(1, 8'h46, "R5 page2 write ignored");

        wr(0, 8'h62);
        for (int i = 1; i <= 6; i++) wr(4'(i), 8'(8'h0F + i));
        wr(7, 8'h4C); wr(8, 8'hA5);
        rd(3, 8'h12, "R4 station byte2");
        rd(7, 8'h4C, "R4 curr");
        rd(8, 8'hA5, "R4 mcast");
        chk(2, 8'h11, "R4 station port");

        wr(0, 8'hE2);
        rd(0, 8'hE2, "R2 cmd page3");
        rd(1, 8'h00, "R5 page3 zero");
        wr(0, 8'h22);
        rd(3, 8'h7F, "R3 boundary kept");

        wr(15, 8'h01);
        pulse(8'h01);
        chk(1, 8'h01, "R8 irq on");
        rd(7, 8'h01, "R6 status set");
        wr(7, 8'h01);
        chk(1, 8'h00, "R6 cleared irq");
        pulse(8'h04);
        chk(1, 8'h00, "R8 masked");
        wr_ev(7, 8'h05, 8'h01);
        rd(7, 8'h01, "R7 set beats clear");
        chk(1, 8'h01, "R7 irq");

        wr(0, 8'h26);
        rd(0, 8'h26, "R9 tx set");
        wr(0, 8'h22);
        rd(0, 8'h26, "R9 zero write");
        pulse(8'h02);
        rd(0, 8'h22, "R9 tx retired");
        chk(4, 8'h00, "R9 tx port");

        wr(0, 8'h0A);
        rd(0, 8'h0A, "R10 remote read");
        pulse(8'h40);
        rd(0, 8'h22, "R10 rdma done");

        wr(7, 8'hFF);
        wr(0, 8'h21);
        rd(0, 8'h21, "R11 draining");
        rd(7, 8'h00, "R11 drain c2");
        rd(7, 8'h00, "R11 drain c3");
        rd(7, 8'h00, "R11 drain c4");
        rd(7, 8'h80, "R11 halted");
        wr(0, 8'h22);
        rd(0, 8'h22, "R12 restart");
        wr(0, 8'h23);
        rd(0, 8'h21, "R11 stop wins");

        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule